// File: doc/BRIEF.md
# Set-Associative Cache Tag Profiler

This block models the tag side of a set-associative cache. It keeps no data. It sorts each memory reference into a hit or a miss and counts the misses. A reference arrives as a byte address and a byte length on a valid/ready handshake. The block splits the address into a set index and a tag using plain bit fields. It then looks the tag up in the chosen set, one way per clock. When the lookup ends, it pulses `done` and reports whether the reference missed. Every miss allocates the line, whether the reference is a read or a write, so the caller never says which kind it is.

Each set keeps its tags in recency order, with way 0 the most recent and the last way the least recent. A hit moves the tag to the front. A miss pushes the new tag in at the front and drops the last way. A reference whose final byte falls in the next set, wrapping from the last set to set 0, touches two lines. Both lines are looked up and updated, start line first. The reference still counts as one access, and it misses if either line misses. A reference whose final byte lands anywhere else is rejected with an error pulse. Associativity, set count, line size and counter width are parameters, and each must be a power of two. Associativity 1 gives a direct-mapped cache.

Top module: `lru_tag_profiler`

## Requirements
- R1: The set index is `(in_addr >> log2(LINE_BYTES)) & (SETS-1)`. The tag is `in_addr >> (log2(LINE_BYTES)+log2(SETS))`. After reset every stored tag is zero, so a reference whose tag is zero hits in any set.
- R2: After reset, `in_ready` is 1, `done` and `err` are 0 and `miss_count` is 0. A reference is taken when `in_valid` and `in_ready` are both 1. From then on `in_ready` stays 0 until the cycle that carries the result. The result is a one-cycle `done` pulse, with `done_miss` set to 1 for a miss and 0 for a hit.
- R3: A hit in way 0 leaves the set's order unchanged. A hit in way i > 0 moves that tag to way 0 and moves ways 0..i-1 down by one.
- R4: On a miss, the new tag goes into way 0, every other way moves down by one, and the tag that was in the last way is evicted.
- R5: The end address is `in_addr + in_size - 1`. If its set equals the start set, the reference is one lookup with the start tag, even when the reference fills the line to its last byte.
- R6: If the end set equals (start set + 1) mod SETS, the block looks up and updates the start line first and then the end line. The end line uses the tag of the end address. The single result is a miss if either line missed, and a hit only if both hit.
- R7: If the end set is neither the start set nor the next set, `err` pulses for one cycle in place of `done`. No set is changed and `miss_count` keeps its value.
- R8: `miss_count` rises by exactly one in the cycle that `done` reports a miss. It never changes otherwise, and it holds at its all-ones value.
- R9: With WAYS = 1 the block is direct-mapped: a different tag in the same set always misses and replaces the stored tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A reference is offered |
| in_ready | output | 1 | Block is idle and takes a reference |
| in_addr | input | ADDR_W | Byte address of the first byte |
| in_size | input | SIZE_W | Length of the reference in bytes, at least 1 |
| done | output | 1 | One-cycle pulse: lookup finished |
| done_miss | output | 1 | With `done`: 1 = miss, 0 = hit |
| err | output | 1 | One-cycle pulse: reference spans an illegal set range |
| miss_count | output | CNT_W | Saturating count of missed references |

## Verification
The assertions take for granted that `in_size` is never zero and that `in_addr + in_size - 1` does not wrap past the top of the address space. Under those limits the end address always lies at or after the start address. The stimulus keeps within these limits: every length it offers is between 1 and 18 bytes, and every address sits far below the top of the address space. The stimulus changes `in_valid` only between clock edges, and it offers a new reference only after the previous one has produced `done` or `err`. That keeps the handshake checks free of back-to-back overlap.

// File: rtl/tp_pkg.sv
package tp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LINE_A,
        ST_LINE_B
    } tp_state_e;

    typedef enum logic [1:0] {
        REF_ONE,
        REF_TWO,
        REF_BAD
    } tp_kind_e;
endpackage

// File: rtl/tp_ref_split.sv
module tp_ref_split #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 5,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 4,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int SET_W = (IDX_W > 0) ? IDX_W : 1,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [SET_W-1:0]  set_a,
    output logic [SET_W-1:0]  set_b,
    output logic [TAG_W-1:0]  tag_a,
    output logic [TAG_W-1:0]  tag_b,
    output tp_pkg::tp_kind_e  kind
);
    localparam logic [ADDR_W-1:0] SET_MASK = ADDR_W'(SETS - 1);

    logic [ADDR_W-1:0] end_addr;
    logic [ADDR_W-1:0] line_a, line_b;
    logic [ADDR_W-1:0] idx_a, idx_b, idx_next;

    always_comb begin
        end_addr = addr + ADDR_W'(size) - ADDR_W'(1);
        line_a   = addr >> OFF_W;
        line_b   = end_addr >> OFF_W;
        idx_a    = line_a & SET_MASK;
        idx_b    = line_b & SET_MASK;
        idx_next = (idx_a + ADDR_W'(1)) & SET_MASK;
        set_a    = SET_W'(idx_a);
        set_b    = SET_W'(idx_b);
        tag_a    = TAG_W'(addr >> (OFF_W + IDX_W));
        tag_b    = TAG_W'(end_addr >> (OFF_W + IDX_W));
        if (idx_b == idx_a) begin
            kind = tp_pkg::REF_ONE;
        end else if (idx_b == idx_next) begin
            kind = tp_pkg::REF_TWO;
        end else begin
            kind = tp_pkg::REF_BAD;
        end
    end
endmodule

// File: rtl/tp_way_shift.sv
module tp_way_shift #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 26,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] ways_in,
    input  logic [TAG_W-1:0]           tag_in,
    input  logic [WAY_W-1:0]           pos,
    output logic [WAYS-1:0][TAG_W-1:0] ways_out
);
    for (genvar j = 0; j < WAYS; j++) begin : g_way
        if (j == 0) begin : g_front
            assign ways_out[0] = tag_in;
        end else begin : g_rest
            assign ways_out[j] = (WAY_W'(j) <= pos) ? ways_in[j-1] : ways_in[j];
        end
    end
endmodule

// File: rtl/tp_sat_counter.sv
module tp_sat_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

    a_r8_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/lru_tag_profiler.sv
module lru_tag_profiler #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 5,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int CNT_W      = 64,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int SET_W = (IDX_W > 0) ? IDX_W : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [SIZE_W-1:0] in_size,
    output logic              done,
    output logic              done_miss,
    output logic              err,
    output logic [CNT_W-1:0]  miss_count
);
    import tp_pkg::*;

    if (((LINE_BYTES & (LINE_BYTES - 1)) != 0) || ((SETS & (SETS - 1)) != 0) ||
        ((WAYS & (WAYS - 1)) != 0) || (LINE_BYTES < 1) || (SETS < 1) || (WAYS < 1)) begin : g_bad_param
        $error("lru_tag_profiler: LINE_BYTES, SETS and WAYS must be powers of two");
    end

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    typedef logic [WAYS-1:0][TAG_W-1:0] set_t;

    typedef struct packed {
        tp_state_e              st;
        logic [WAY_W-1:0]       way;
        logic [SET_W-1:0]       set_a;
        logic [SET_W-1:0]       set_b;
        logic [TAG_W-1:0]       tag_a;
        logic [TAG_W-1:0]       tag_b;
        logic                   two;
        logic                   missed;
        logic                   done;
        logic                   done_miss;
        logic                   err;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tags;
    } ctl_t;

    ctl_t d, q;

    logic [SET_W-1:0] req_set_a, req_set_b;
    logic [TAG_W-1:0] req_tag_a, req_tag_b;
    tp_kind_e         req_kind;

    logic [SET_W-1:0] cur_set;
    logic [TAG_W-1:0] cur_tag;
    set_t             cur_ways, new_ways;
    logic             hit_now, last_now, upd, fin_miss;
    logic [WAY_W-1:0] ins_pos;

    tp_ref_split #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS)
    ) u_split (
        .addr(in_addr), .size(in_size),
        .set_a(req_set_a), .set_b(req_set_b),
        .tag_a(req_tag_a), .tag_b(req_tag_b),
        .kind(req_kind)
    );

    always_comb begin
        cur_set  = (q.st == ST_LINE_B) ? q.set_b : q.set_a;
        cur_tag  = (q.st == ST_LINE_B) ? q.tag_b : q.tag_a;
        cur_ways = q.tags[cur_set];
        hit_now  = (cur_ways[q.way] == cur_tag);
        last_now = (q.way == LAST_WAY);
        ins_pos  = hit_now ? q.way : LAST_WAY;
    end

    tp_way_shift #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_shift (
        .ways_in(cur_ways), .tag_in(cur_tag), .pos(ins_pos), .ways_out(new_ways)
    );

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.done_miss = 1'b0;
        d.err       = 1'b0;
        upd         = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (req_kind == REF_BAD) begin
                        d.err = 1'b1;
                    end else begin
                        d.st     = ST_LINE_A;
                        d.way    = '0;
                        d.set_a  = req_set_a;
                        d.set_b  = req_set_b;
                        d.tag_a  = req_tag_a;
                        d.tag_b  = req_tag_b;
                        d.two    = (req_kind == REF_TWO);
                        d.missed = 1'b0;
                    end
                end
            end
            ST_LINE_A, ST_LINE_B: begin
                if (hit_now || last_now) begin
                    upd              = 1'b1;
                    d.tags[cur_set]  = new_ways;
                    if ((q.st == ST_LINE_A) && q.two) begin
                        d.st     = ST_LINE_B;
                        d.way    = '0;
                        d.missed = !hit_now;
                    end else begin
                        d.st        = ST_IDLE;
                        d.done      = 1'b1;
                        d.done_miss = q.missed || !hit_now;
                    end
                end else begin
                    d.way = q.way + WAY_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
        fin_miss = d.done && d.done_miss;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    tp_sat_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(fin_miss), .count(miss_count)
    );

    assign in_ready  = (q.st == ST_IDLE);
    assign done      = q.done;
    assign done_miss = q.done_miss;
    assign err       = q.err;

    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!in_ready));
    a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_front_hit_keeps_order: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && hit_now && (q.way == '0)) |=> $stable(q.tags));
    a_r4_front_gets_tag: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (q.tags[$past(cur_set)][0] == $past(cur_tag)));
    a_r7_err_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(in_valid && in_ready) && !done));
    a_r7_err_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(q.tags));
endmodule

// File: tb/lru_tag_profiler_bench.sv
module lru_tag_profiler_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic        a_valid = 1'b0, a_ready, a_done, a_miss, a_err;
    logic [31:0] a_addr = '0;
    logic [4:0]  a_size = 5'd1;
    logic [63:0] a_cnt;

    logic        b_valid = 1'b0, b_ready, b_done, b_miss, b_err;
    logic [31:0] b_addr = '0;
    logic [4:0]  b_size = 5'd1;
    logic [1:0]  b_cnt;

    lru_tag_profiler u_lru_tag_profiler (
        .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_ready(a_ready),
        .in_addr(a_addr), .in_size(a_size), .done(a_done), .done_miss(a_miss),
        .err(a_err), .miss_count(a_cnt)
    );

    lru_tag_profiler #(.WAYS(1), .CNT_W(2)) u_dm (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_ready(b_ready),
        .in_addr(b_addr), .in_size(b_size), .done(b_done), .done_miss(b_miss),
        .err(b_err), .miss_count(b_cnt)
    );

    // address layout for both instances: 16-byte lines, 4 sets
    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return (32'(tag) << 6) | (32'(set) << 4) | 32'(off);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_ref(input bit dm, input logic [31:0] addr, input int size,
                          input bit exp_err, input bit exp_miss,
                          input longint exp_cnt, input string req);
        bit got_done = 1'b0, got_err = 1'b0, miss_v = 1'b0, rdy_low = 1'b1;
        longint cnt_v;
        @(negedge clk);
        check(dm ? b_ready : a_ready, "R2", "ready before offer", 0, 1);
        if (dm) begin b_addr = addr; b_size = 5'(size); b_valid = 1'b1; end
        else    begin a_addr = addr; a_size = 5'(size); a_valid = 1'b1; end
        @(negedge clk);
        a_valid = 1'b0;
        b_valid = 1'b0;
        for (int n = 0; n < 40; n++) begin
            got_done = dm ? b_done : a_done;
            got_err  = dm ? b_err  : a_err;
            if (got_done || got_err) break;
            if (dm ? b_ready : a_ready) rdy_low = 1'b0;
            @(negedge clk);
        end
        miss_v = dm ? b_miss : a_miss;
        cnt_v  = dm ? longint'(b_cnt) : longint'(a_cnt);
        check(rdy_low, "R2", "in_ready low while busy", 1, 0);
        if (exp_err) begin
            check(got_err && !got_done, req, "err pulse", got_err, 1);
        end else begin
            check(got_done && !got_err, req, "done pulse", got_done, 1);
            check(miss_v == exp_miss, req, "done_miss", miss_v, exp_miss);
        end
        check(cnt_v == exp_cnt, req, "miss_count", cnt_v, exp_cnt);
        @(negedge clk);
        check(!(dm ? b_done : a_done), "R2", "done is one cycle", 1, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(a_ready == 1'b1, "R2", "reset in_ready", a_ready, 1);
        check(!a_done && !a_err, "R2", "reset done/err", a_done, 0);
        check(a_cnt == 64'd0, "R8", "reset miss_count", a_cnt, 0);
    endtask

    task automatic t_zero_tag;
        do_ref(0, mk(0, 2, 0), 4, 0, 0, 0, "R1");
    endtask

    task automatic t_recency;
        do_ref(0, mk(1, 1, 0), 1, 0, 1, 1, "R4");
        do_ref(0, mk(2, 1, 0), 1, 0, 1, 2, "R4");
        do_ref(0, mk(3, 1, 0), 1, 0, 1, 3, "R4");
        do_ref(0, mk(4, 1, 0), 1, 0, 1, 4, "R4");
        do_ref(0, mk(1, 1, 0), 1, 0, 0, 4, "R3");  // hit in last way
        do_ref(0, mk(5, 1, 0), 1, 0, 1, 5, "R4");  // evicts tag 2
        do_ref(0, mk(2, 1, 0), 1, 0, 1, 6, "R4");  // tag 2 was evicted
        do_ref(0, mk(1, 1, 0), 1, 0, 0, 6, "R3");
        do_ref(0, mk(4, 1, 0), 1, 0, 0, 6, "R3");
        do_ref(0, mk(3, 1, 0), 1, 0, 1, 7, "R4");
        do_ref(0, mk(3, 1, 0), 1, 0, 0, 7, "R3");  // way 0 hit
    endtask

    task automatic t_mapping;
        do_ref(0, mk(3, 1, 9), 1, 0, 0, 7, "R1");  // other offset, same line
        do_ref(0, mk(3, 0, 0), 1, 0, 1, 8, "R1");  // same tag, other set
    endtask

    task automatic t_single_line;
        do_ref(0, mk(0, 2, 0), 16, 0, 0, 8, "R5");  // fills line to last byte
    endtask

    task automatic t_straddle;
        do_ref(0, mk(0, 2, 12), 8, 0, 0, 8, "R6");   // both hit
        do_ref(0, mk(7, 0, 8), 16, 0, 1, 9, "R6");   // both miss: one count
        do_ref(0, mk(7, 0, 14), 4, 0, 0, 9, "R6");   // both now hit
        do_ref(0, mk(9, 0, 10), 8, 0, 1, 10, "R6");
        do_ref(0, mk(0, 3, 12), 8, 0, 1, 11, "R6");  // wrap, end tag 1 misses
        do_ref(0, mk(1, 0, 0), 1, 0, 0, 11, "R6");   // end line was installed
        do_ref(0, mk(4, 0, 12), 8, 0, 1, 12, "R6");  // start miss, end hit
    endtask

    task automatic t_illegal;
        do_ref(0, mk(5, 0, 15), 18, 1, 0, 12, "R7");
        do_ref(0, mk(7, 0, 0), 1, 0, 0, 12, "R7");   // set 0 untouched
    endtask

    task automatic t_direct;
        do_ref(1, mk(0, 0, 0), 1, 0, 0, 0, "R9");
        do_ref(1, mk(1, 0, 0), 1, 0, 1, 1, "R9");
        do_ref(1, mk(1, 0, 3), 1, 0, 0, 1, "R9");
        do_ref(1, mk(2, 0, 0), 1, 0, 1, 2, "R9");
        do_ref(1, mk(1, 0, 0), 1, 0, 1, 3, "R9");
        do_ref(1, mk(2, 0, 0), 1, 0, 1, 3, "R8");  // saturated
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero_tag();
        t_recency();
        t_mapping();
        t_single_line();
        t_straddle();
        t_illegal();
        t_direct();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule